// File: doc/BRIEF.md
# MMU Fault Status Register

This block keeps the status and control word of a memory-management unit. A translation unit reports each access through a valid-qualified strobe carrying three fault flags (page not resident, block outside page length, write to a read-only page) together with the access mode, the address-space bit and the page number. Any fault, or an access made in the illegal mode, logs a cause bit and raises a one-cycle abort request. The first fault after the cause bits were cleared also captures the mode, space and page of the faulting reference. That context is kept until software clears the cause bits.

The word also holds the relocation enable, which drives the translation unit, and a trap enable. A potential-trap strobe is always logged in the word. When traps are enabled at that moment, a trap is armed and is raised as a one-cycle request at the next instruction-complete strobe. Both requests vector through a fixed kernel virtual address, 250 octal. The fault report has a valid strobe and no ready signal: the block accepts one report every cycle and never applies back-pressure. The register port and the request outputs are plain pins.

Top module: `mmu_fault_status`

## Requirements
- R1: After reset the read value is 16'h0080 (only bit 7 set), relocation is off, no request is raised, and the vector output is 16'h00A8 (250 octal).
- R2: A valid access with the non-resident flag sets bit 15, with the length flag sets bit 14, and with the read-only flag sets bit 13. Several flags in one access set several bits. Any of them raises abort_req for exactly the cycle after the access.
- R3: A valid access with mode 2'b10 (Kernel=00, Supervisor=01, User=11, 10 illegal) sets bit 15 and raises abort_req, even when no fault flag is present.
- R4: When bits 15..13 are all clear, a fault captures the access mode into bits 6..5, the space bit into bit 4 and the page number (counted from 0) into bits 3..1.
- R5: While any of bits 15..13 is set, later faults add their cause bits but leave bits 6..1 unchanged.
- R6: A potential-trap strobe always sets bit 12. While bit 9 is 0, no trap request follows.
- R7: If bit 9 is 1 when a potential trap occurs, trap_req is raised for one cycle, in the cycle after the next instruction-complete strobe, and never at any other time.
- R8: If a trap is armed and the same instruction then writes bit 9 to 0, the trap is still raised at instruction end. If bit 9 is set only after the potential trap, no trap follows.
- R9: Software writes to bits 15..12 store the written value and never raise abort_req or trap_req. Writing zeros clears them.
- R10: Bit 7 ignores software writes. A fault clears it, and an instruction-complete strobe in a cycle without a fault sets it.
- R11: Bit 0 is writable and drives reloc_en. Bits 11, 10 and 8 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access report valid |
| flt_nonres | input | 1 | Page not resident |
| flt_len | input | 1 | Block outside page length |
| flt_ro | input | 1 | Write to read-only page |
| acc_mode | input | 2 | Access mode of the report |
| acc_space | input | 1 | Address-space bit of the report |
| acc_page | input | 3 | Page number of the report |
| pot_trap | input | 1 | Potential-trap strobe |
| instr_end | input | 1 | Instruction-complete strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read value |
| reloc_en | output | 1 | Relocation enable |
| abort_req | output | 1 | Abort request pulse |
| trap_req | output | 1 | Trap request pulse |
| vec_addr | output | 16 | Fixed vector address |

## Verification
The properties assume that every strobe is a single-cycle pulse. They also assume that the fault flags carry meaning only while acc_valid is high, and that a register write does not land in the same cycle as a fault or an instruction end when the stability of bits 7 and 6..1 is checked. The bench drives each strobe for exactly one cycle. It keeps the fault flags low outside a valid access and issues register writes in cycles of their own. The single exception is the trap-disable ordering case, which spreads the strobe, the write and the instruction end over separate cycles.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
  localparam int unsigned SR_W   = 16;
  localparam int unsigned PAGE_W = 3;

  localparam int unsigned BIT_NONRES = 15;
  localparam int unsigned BIT_LEN    = 14;
  localparam int unsigned BIT_RO     = 13;
  localparam int unsigned BIT_TRAP   = 12;
  localparam int unsigned BIT_TEN    = 9;
  localparam int unsigned BIT_DONE   = 7;
  localparam int unsigned BIT_MODE   = 5;
  localparam int unsigned BIT_SPACE  = 4;
  localparam int unsigned BIT_PAGE   = 1;
  localparam int unsigned BIT_RELOC  = 0;

  typedef enum logic [1:0] {
    MODE_KERNEL = 2'b00,
    MODE_SUPER  = 2'b01,
    MODE_BAD    = 2'b10,
    MODE_USER   = 2'b11
  } acc_mode_e;

  typedef struct packed {
    acc_mode_e         mode;
    logic              space;
    logic [PAGE_W-1:0] page;
  } fault_ctx_t;

  typedef struct packed {
    logic nonres;
    logic len;
    logic ro;
  } fault_cause_t;
endpackage

// File: rtl/mfs_fault_log.sv
module mfs_fault_log
  import mfs_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         acc_valid,
  input  logic         flt_nonres,
  input  logic         flt_len,
  input  logic         flt_ro,
  input  fault_ctx_t   acc_ctx,
  input  logic         wr_en,
  input  fault_cause_t wr_cause,
  input  fault_ctx_t   wr_ctx,
  output fault_cause_t cause,
  output fault_ctx_t   ctx,
  output logic         fault_hit,
  output logic         abort_pulse
);
  fault_cause_t new_cause, base_cause, cause_d;
  fault_ctx_t   base_ctx, ctx_d;
  logic         illegal;

  always_comb begin
    illegal          = (acc_ctx.mode == MODE_BAD);
    new_cause.nonres = acc_valid & (flt_nonres | illegal);
    new_cause.len    = acc_valid & flt_len;
    new_cause.ro     = acc_valid & flt_ro;
    fault_hit        = |new_cause;
    // a same-cycle write is applied first, hardware events on top
    base_cause = wr_en ? wr_cause : cause;
    base_ctx   = wr_en ? wr_ctx   : ctx;
    cause_d    = fault_cause_t'(base_cause | new_cause);
    // context only follows the first fault after the causes were cleared
    ctx_d      = (fault_hit && (base_cause == '0)) ? acc_ctx : base_ctx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause       <= '0;
      ctx         <= '0;
      abort_pulse <= 1'b0;
    end else begin
      cause       <= cause_d;
      ctx         <= ctx_d;
      abort_pulse <= fault_hit;
    end
  end
endmodule

// File: rtl/mfs_trap_ctl.sv
module mfs_trap_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic pot_trap,
  input  logic instr_end,
  input  logic wr_en,
  input  logic wr_logged,
  input  logic wr_enable,
  output logic logged,
  output logic enable,
  output logic trap_pulse
);
  logic armed, armed_all, arm_now;

  always_comb begin
    // enable is sampled before any write of this cycle takes effect
    arm_now   = pot_trap & enable;
    armed_all = armed | arm_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      logged     <= 1'b0;
      enable     <= 1'b0;
      armed      <= 1'b0;
      trap_pulse <= 1'b0;
    end else begin
      logged     <= (wr_en ? wr_logged : logged) | pot_trap;
      enable     <= wr_en ? wr_enable : enable;
      armed      <= instr_end ? 1'b0 : armed_all;
      trap_pulse <= instr_end & armed_all;
    end
  end
endmodule

// File: rtl/mfs_ctl_bits.sv
module mfs_ctl_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_reloc,
  input  logic fault_hit,
  input  logic instr_end,
  output logic reloc,
  output logic done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reloc <= 1'b0;
      done  <= 1'b1;
    end else begin
      reloc <= wr_en ? wr_reloc : reloc;
      if (fault_hit)      done <= 1'b0;
      else if (instr_end) done <= 1'b1;
    end
  end
endmodule

// File: rtl/mmu_fault_status.sv
module mmu_fault_status
  import mfs_pkg::*;
#(
  parameter logic [SR_W-1:0] VEC_ADDR = 16'o250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              flt_nonres,
  input  logic              flt_len,
  input  logic              flt_ro,
  input  logic [1:0]        acc_mode,
  input  logic              acc_space,
  input  logic [PAGE_W-1:0] acc_page,
  input  logic              pot_trap,
  input  logic              instr_end,
  input  logic              reg_wr,
  input  logic [SR_W-1:0]   reg_wdata,
  output logic [SR_W-1:0]   reg_rdata,
  output logic              reloc_en,
  output logic              abort_req,
  output logic              trap_req,
  output logic [SR_W-1:0]   vec_addr
);
  localparam int unsigned CTX_W = $bits(fault_ctx_t);

  fault_ctx_t   acc_ctx, wr_ctx, ctx;
  fault_cause_t wr_cause, cause;
  logic         fault_hit, trap_logged, trap_en, done, reloc;
  logic         wdata_unused;

  assign acc_ctx  = fault_ctx_t'({acc_mode, acc_space, acc_page});
  assign wr_ctx   = fault_ctx_t'(reg_wdata[BIT_PAGE +: CTX_W]);
  assign wr_cause = fault_cause_t'(reg_wdata[BIT_RO +: 3]);
  assign wdata_unused = ^{reg_wdata[11:10], reg_wdata[8], reg_wdata[BIT_DONE]};

  mfs_fault_log u_log (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .flt_nonres (flt_nonres),
    .flt_len    (flt_len),
    .flt_ro     (flt_ro),
    .acc_ctx    (acc_ctx),
    .wr_en      (reg_wr),
    .wr_cause   (wr_cause),
    .wr_ctx     (wr_ctx),
    .cause      (cause),
    .ctx        (ctx),
    .fault_hit  (fault_hit),
    .abort_pulse(abort_req)
  );

  mfs_trap_ctl u_trap (
    .clk       (clk),
    .rst_n     (rst_n),
    .pot_trap  (pot_trap),
    .instr_end (instr_end),
    .wr_en     (reg_wr),
    .wr_logged (reg_wdata[BIT_TRAP]),
    .wr_enable (reg_wdata[BIT_TEN]),
    .logged    (trap_logged),
    .enable    (trap_en),
    .trap_pulse(trap_req)
  );

  mfs_ctl_bits u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .wr_reloc (reg_wdata[BIT_RELOC]),
    .fault_hit(fault_hit),
    .instr_end(instr_end),
    .reloc    (reloc),
    .done     (done)
  );

  always_comb begin
    reg_rdata                       = '0;
    reg_rdata[BIT_RO +: 3]          = cause;
    reg_rdata[BIT_TRAP]             = trap_logged;
    reg_rdata[BIT_TEN]              = trap_en;
    reg_rdata[BIT_DONE]             = done;
    reg_rdata[BIT_PAGE +: CTX_W]    = ctx;
    reg_rdata[BIT_RELOC]            = reloc;
  end

  assign reloc_en = reloc;
  assign vec_addr = VEC_ADDR;
endmodule

// File: rtl/mfs_checker.sv
module mfs_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        flt_nonres,
  input logic        flt_len,
  input logic        flt_ro,
  input logic [1:0]  acc_mode,
  input logic        pot_trap,
  input logic        instr_end,
  input logic        reg_wr,
  input logic [15:0] reg_wdata,
  input logic [15:0] reg_rdata,
  input logic        reloc_en,
  input logic        abort_req,
  input logic        trap_req
);
  p_abort_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && (flt_nonres || flt_len || flt_ro) |=> abort_req);

  p_illegal_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && (acc_mode == 2'b10) |=> abort_req && reg_rdata[15]);

  p_ctx_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|reg_rdata[15:13]) && !reg_wr |=> $stable(reg_rdata[6:1]));

  p_trap_logged_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pot_trap |=> reg_rdata[12]);

  p_trap_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(instr_end));

  p_abort_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> $past(acc_valid));

  p_done_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !acc_valid && !instr_end |=> $stable(reg_rdata[7]));

  p_reloc_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reloc_en == $past(reg_wdata[0]));
endmodule

bind mmu_fault_status mfs_checker i_mfs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .flt_nonres(flt_nonres),
  .flt_len   (flt_len),
  .flt_ro    (flt_ro),
  .acc_mode  (acc_mode),
  .pot_trap  (pot_trap),
  .instr_end (instr_end),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .reloc_en  (reloc_en),
  .abort_req (abort_req),
  .trap_req  (trap_req)
);

// File: tb/test_mmu_fault_status.sv
module test_mmu_fault_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, flt_nonres = 1'b0, flt_len = 1'b0, flt_ro = 1'b0;
  logic [1:0]  acc_mode = 2'b00;
  logic        acc_space = 1'b0;
  logic [2:0]  acc_page = 3'd0;
  logic        pot_trap = 1'b0, instr_end = 1'b0, reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata, vec_addr;
  logic        reloc_en, abort_req, trap_req;
  int          n_run = 0, n_fail = 0;
  logic        done_flag = 1'b0;

  always #2 clk = ~clk;

  mmu_fault_status i_mmu_fault_status (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .flt_nonres(flt_nonres),
    .flt_len(flt_len), .flt_ro(flt_ro), .acc_mode(acc_mode), .acc_space(acc_space),
    .acc_page(acc_page), .pot_trap(pot_trap), .instr_end(instr_end), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reloc_en(reloc_en),
    .abort_req(abort_req), .trap_req(trap_req), .vec_addr(vec_addr)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic access(logic nr, logic ln, logic ro, logic [1:0] md, logic sp, logic [2:0] pg);
    @(negedge clk);
    acc_valid = 1'b1; flt_nonres = nr; flt_len = ln; flt_ro = ro;
    acc_mode = md; acc_space = sp; acc_page = pg;
    step();
    acc_valid = 1'b0; flt_nonres = 1'b0; flt_len = 1'b0; flt_ro = 1'b0;
  endtask

  task automatic wr(logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic pulse_pot();
    @(negedge clk); pot_trap = 1'b1; step(); pot_trap = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk); instr_end = 1'b1; step(); instr_end = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rdata", reg_rdata, 16'h0080);
    check("R1 reloc_en", {15'd0, reloc_en}, 16'd0);
    check("R1 abort_req", {15'd0, abort_req}, 16'd0);
    check("R1 trap_req", {15'd0, trap_req}, 16'd0);
    check("R1 vec_addr", vec_addr, 16'h00A8);
  endtask

  task automatic t_abort_causes();
    access(1, 0, 0, 2'b11, 1, 3'd5);
    check("R2 abort_req", {15'd0, abort_req}, 16'd1);
    check("R4 capture", reg_rdata, 16'h807A);
    step();
    check("R2 one cycle", {15'd0, abort_req}, 16'd0);
    wr(16'h0000);
    access(1, 1, 0, 2'b00, 0, 3'd2);
    check("R2 two causes", reg_rdata, 16'hC004);
  endtask

  task automatic t_freeze();
    access(0, 0, 1, 2'b01, 1, 3'd7);
    check("R5 frozen ctx", reg_rdata, 16'hE004);
    check("R5 abort still", {15'd0, abort_req}, 16'd1);
    wr(16'h0000);
  endtask

  task automatic t_illegal();
    access(0, 0, 0, 2'b10, 0, 3'd3);
    check("R3 abort", {15'd0, abort_req}, 16'd1);
    check("R3 rdata", reg_rdata, 16'h8046);
    wr(16'h0000);
  endtask

  task automatic t_done_bit();
    access(0, 1, 0, 2'b00, 0, 3'd0);
    check("R10 cleared", {15'd0, reg_rdata[7]}, 16'd0);
    pulse_end();
    check("R10 set", {15'd0, reg_rdata[7]}, 16'd1);
    wr(16'h0000);
    check("R10 write ignored", reg_rdata, 16'h0080);
  endtask

  task automatic t_trap_disabled();
    pulse_pot();
    check("R6 logged", {15'd0, reg_rdata[12]}, 16'd1);
    pulse_end();
    check("R6 no trap", {15'd0, trap_req}, 16'd0);
    wr(16'h0000);
  endtask

  task automatic t_trap_enabled();
    wr(16'h0200);
    pulse_pot();
    check("R7 not before end", {15'd0, trap_req}, 16'd0);
    step();
    check("R7 waits for end", {15'd0, trap_req}, 16'd0);
    pulse_end();
    check("R7 trap", {15'd0, trap_req}, 16'd1);
    step();
    check("R7 one cycle", {15'd0, trap_req}, 16'd0);
  endtask

  task automatic t_trap_race();
    wr(16'h0200);
    pulse_pot();
    wr(16'h0000);
    check("R8 bit9 cleared", {15'd0, reg_rdata[9]}, 16'd0);
    pulse_end();
    check("R8 trap kept", {15'd0, trap_req}, 16'd1);
    wr(16'h0000);
    pulse_pot();
    wr(16'h0200);
    pulse_end();
    check("R8 late enable", {15'd0, trap_req}, 16'd0);
    wr(16'h0000);
  endtask

  task automatic t_sw_bits();
    wr(16'hF200);
    check("R9 no abort", {15'd0, abort_req}, 16'd0);
    check("R9 stored", {12'd0, reg_rdata[15:12]}, 16'hF);
    pulse_end();
    check("R9 no trap", {15'd0, trap_req}, 16'd0);
    wr(16'h0000);
    check("R9 cleared", {12'd0, reg_rdata[15:12]}, 16'h0);
  endtask

  task automatic t_reloc();
    wr(16'hFFFF);
    check("R11 reloc on", {15'd0, reloc_en}, 16'd1);
    check("R11 unused zero", reg_rdata & 16'h0D00, 16'h0000);
    wr(16'h0000);
    check("R11 reloc off", {15'd0, reloc_en}, 16'd0);
  endtask

  initial begin
    #400000;
    if (!done_flag) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step();
    t_reset();
    t_abort_causes();
    t_freeze();
    t_illegal();
    t_done_bit();
    t_trap_disabled();
    t_trap_enabled();
    t_trap_race();
    t_sw_bits();
    t_reloc();
    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule